// File: doc/BRIEF.md
# Card Window Address Decoder

This block sits between a host bus and a pair of removable-card sockets. It holds eight programmable windows, each made of a base word and an option word. Every host request is compared against all windows in parallel. The block reports, one clock later, which window claimed the address and the card-relative offset. It also reports the socket the window points at, the access space, the port width and whether a write hit a protected window. The strobe timing fields of the winning window are handed on to the strobe sequencer.

There is no offset translation. The card address is the host address minus the window base, so a window maps the card from card offset zero upward. Window sizes are powers of two chosen by a 5-bit code. The code order is permuted rather than monotonic, and four code values are reserved.

Top module: `card_window_decoder`

## Requirements
- R1: After reset every window is invalid (base and option cleared), all response outputs are zero, and any lookup misses.
- R2: A configuration write selects the window with `cfg_addr[3:1]` and the word with `cfg_addr[0]` (0 = base, 1 = option). It takes effect for lookups from the next cycle on. A lookup in the same cycle as the write still sees the old contents.
- R3: Option bits 31:27 hold the size code, mapped to log2(size) as follows. Codes 0..15: 0,1,3,2,7,6,4,5,15,14,12,13,8,9,11,10. Code 16: 28. Codes 20, 21, 23: 24, 25, 26. Codes 24..31: 16,17,19,18,23,22,20,21.
- R4: Size codes 17, 18, 19 and 22 are reserved; a window carrying one never hits.
- R5: A window hits when option bit 0 is set and the host address with its low log2(size) bits cleared equals the whole base word. A base with any bit set below the size boundary never hits.
- R6: When several windows hit, the one with the lowest index is reported.
- R7: On a hit, `rsp_win` carries the window index and `rsp_card_addr` carries host address minus base.
- R8: On a hit, `rsp_slot` is option bit 2, `rsp_space` is option bits 4:3 (00 common, 10 attribute, 11 I/O) and `rsp_wide` is option bit 6.
- R9: On a hit, `rsp_hold` is option bits 19:16, `rsp_setup` is bits 15:12 and `rsp_strobe` is bits 11:7 of the winning window.
- R10: A write that hits a window with option bit 1 set raises `rsp_wp_err` and leaves `rsp_go` low. Any other hit raises `rsp_go`, and a read never raises `rsp_wp_err`.
- R11: The response registers one cycle after the request: `rsp_valid` follows `req_valid`. On a miss `rsp_hit`, `rsp_go`, `rsp_wp_err` and every field output are zero.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Window index (3:1) and word select (0) |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | Host request is a write |
| req_addr | input | 32 | Host address |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Some window claimed the address |
| rsp_go | output | 1 | Card access may proceed |
| rsp_wp_err | output | 1 | Write to a protected window |
| rsp_win | output | 3 | Index of the winning window |
| rsp_card_addr | output | 32 | Card-relative address |
| rsp_slot | output | 1 | Target socket |
| rsp_space | output | 2 | Access space code |
| rsp_wide | output | 1 | 16-bit port select |
| rsp_hold | output | 4 | Hold time in bus clocks |
| rsp_setup | output | 4 | Setup time in bus clocks |
| rsp_strobe | output | 5 | Strobe length in bus clocks |

## Verification
A configuration write and a lookup can land in the same cycle. Sometimes they hit the very window being rewritten. The bench drives both on one edge twice. The first time, it clears a window's option word while reading inside that window. The second time, it moves a base word onto the address being read. Each lookup must see the window as it was before the write, and the following lookup must see it as written. The size codes are swept in full, probing just below, at the start of, at the top of, and just past each window.

// File: rtl/cwd_pkg.sv
package cwd_pkg;

  typedef struct packed {
    logic [4:0] code;
    logic [6:0] rsvd_hi;
    logic [3:0] hold;
    logic [3:0] setup;
    logic [4:0] strobe;
    logic       wide;
    logic       rsvd_lo;
    logic [1:0] space;
    logic       slot;
    logic       wprot;
    logic       valid;
  } opt_t;

  // Returns {legal, log2(size)} for a size code.
  function automatic logic [5:0] size_of_code(input logic [4:0] code);
    logic [5:0] r;
    case (code)
      5'd0:  r = {1'b1, 5'd0};
      5'd1:  r = {1'b1, 5'd1};
      5'd2:  r = {1'b1, 5'd3};
      5'd3:  r = {1'b1, 5'd2};
      5'd4:  r = {1'b1, 5'd7};
      5'd5:  r = {1'b1, 5'd6};
      5'd6:  r = {1'b1, 5'd4};
      5'd7:  r = {1'b1, 5'd5};
      5'd8:  r = {1'b1, 5'd15};
      5'd9:  r = {1'b1, 5'd14};
      5'd10: r = {1'b1, 5'd12};
      5'd11: r = {1'b1, 5'd13};
      5'd12: r = {1'b1, 5'd8};
      5'd13: r = {1'b1, 5'd9};
      5'd14: r = {1'b1, 5'd11};
      5'd15: r = {1'b1, 5'd10};
      5'd16: r = {1'b1, 5'd28};
      5'd20: r = {1'b1, 5'd24};
      5'd21: r = {1'b1, 5'd25};
      5'd23: r = {1'b1, 5'd26};
      5'd24: r = {1'b1, 5'd16};
      5'd25: r = {1'b1, 5'd17};
      5'd26: r = {1'b1, 5'd19};
      5'd27: r = {1'b1, 5'd18};
      5'd28: r = {1'b1, 5'd23};
      5'd29: r = {1'b1, 5'd22};
      5'd30: r = {1'b1, 5'd20};
      5'd31: r = {1'b1, 5'd21};
      default: r = 6'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cwd_window.sv
module cwd_window
  import cwd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_base,
  input  logic          we_opt,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] lookup_addr,
  output logic          match,
  output logic [AW-1:0] base_q,
  output opt_t          opt_q
);

  logic [5:0]    sz;
  logic [AW-1:0] keep_mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      opt_q  <= '0;
    end else begin
      if (we_base) base_q <= wdata[AW-1:0];
      if (we_opt)  opt_q  <= opt_t'(wdata);
    end
  end

  always_comb begin
    sz        = size_of_code(opt_q.code);
    keep_mask = {AW{1'b1}} << sz[4:0];
    match     = opt_q.valid && sz[5] && ((lookup_addr & keep_mask) == base_q);
  end

endmodule

// File: rtl/cwd_prio.sv
module cwd_prio #(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);

  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/card_window_decoder.sv
module card_window_decoder
  import cwd_pkg::*;
#(
  parameter int NWIN = 8,
  parameter int AW   = 32,
  localparam int IW  = $clog2(NWIN)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [IW:0]   cfg_addr,
  input  logic [31:0]   cfg_wdata,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  output logic          rsp_hit,
  output logic          rsp_go,
  output logic          rsp_wp_err,
  output logic [IW-1:0] rsp_win,
  output logic [AW-1:0] rsp_card_addr,
  output logic          rsp_slot,
  output logic [1:0]    rsp_space,
  output logic          rsp_wide,
  output logic [3:0]    rsp_hold,
  output logic [3:0]    rsp_setup,
  output logic [4:0]    rsp_strobe
);

  logic [NWIN-1:0] match_vec;
  logic [AW-1:0]   base_arr [NWIN];
  opt_t            opt_arr  [NWIN];
  logic            any_hit;
  logic [IW-1:0]   win_idx;
  logic [AW-1:0]   base_sel;
  opt_t            opt_sel;
  logic            hit_now;
  logic            wp_now;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    logic sel;
    assign sel = cfg_we && (cfg_addr[IW:1] == IW'(w));
    cwd_window #(.AW(AW)) u_win (
      .clk         (clk),
      .rst         (rst),
      .we_base     (sel && !cfg_addr[0]),
      .we_opt      (sel && cfg_addr[0]),
      .wdata       (cfg_wdata),
      .lookup_addr (req_addr),
      .match       (match_vec[w]),
      .base_q      (base_arr[w]),
      .opt_q       (opt_arr[w])
    );
  end

  cwd_prio #(.N(NWIN)) u_prio (
    .req (match_vec),
    .any (any_hit),
    .idx (win_idx)
  );

  assign base_sel = base_arr[win_idx];
  assign opt_sel  = opt_arr[win_idx];
  assign hit_now  = req_valid && any_hit;
  assign wp_now   = hit_now && req_write && opt_sel.wprot;

  logic unused_opt_bits;
  assign unused_opt_bits = ^{opt_sel.rsvd_hi, opt_sel.rsvd_lo, opt_sel.code, opt_sel.valid};

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_hit       <= 1'b0;
      rsp_go        <= 1'b0;
      rsp_wp_err    <= 1'b0;
      rsp_win       <= '0;
      rsp_card_addr <= '0;
      rsp_slot      <= 1'b0;
      rsp_space     <= 2'b00;
      rsp_wide      <= 1'b0;
      rsp_hold      <= '0;
      rsp_setup     <= '0;
      rsp_strobe    <= '0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_hit    <= hit_now;
      rsp_go     <= hit_now && !wp_now;
      rsp_wp_err <= wp_now;
      if (hit_now) begin
        rsp_win       <= win_idx;
        rsp_card_addr <= req_addr - base_sel;
        rsp_slot      <= opt_sel.slot;
        rsp_space     <= opt_sel.space;
        rsp_wide      <= opt_sel.wide;
        rsp_hold      <= opt_sel.hold;
        rsp_setup     <= opt_sel.setup;
        rsp_strobe    <= opt_sel.strobe;
      end else begin
        rsp_win       <= '0;
        rsp_card_addr <= '0;
        rsp_slot      <= 1'b0;
        rsp_space     <= 2'b00;
        rsp_wide      <= 1'b0;
        rsp_hold      <= '0;
        rsp_setup     <= '0;
        rsp_strobe    <= '0;
      end
    end
  end

endmodule

// File: rtl/cwd_checker.sv
module cwd_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_write,
  input logic          rsp_valid,
  input logic          rsp_hit,
  input logic          rsp_go,
  input logic          rsp_wp_err,
  input logic [AW-1:0] rsp_card_addr,
  input logic [3:0]    rsp_hold,
  input logic [3:0]    rsp_setup,
  input logic [4:0]    rsp_strobe
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!rsp_valid && !rsp_hit && !rsp_go && !rsp_wp_err));

  assert_wp_blocks_go_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_wp_err |-> (rsp_hit && !rsp_go));

  assert_go_needs_hit_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_go |-> rsp_hit);

  assert_read_no_wp_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> !rsp_wp_err);

  assert_valid_follows_R11: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_idle_follows_R11: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !rsp_hit));

  assert_miss_zero_R11: assert property (@(posedge clk) disable iff (rst)
    !rsp_hit |-> (rsp_card_addr == '0 && rsp_hold == '0 && rsp_setup == '0 && rsp_strobe == '0));

endmodule

bind card_window_decoder cwd_checker #(.AW(AW)) u_chk (.*);

// File: tb/card_window_decoder_test.sv
module card_window_decoder_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [31:0] req_addr = '0;
  logic        rsp_valid, rsp_hit, rsp_go, rsp_wp_err, rsp_slot, rsp_wide;
  logic [2:0]  rsp_win;
  logic [31:0] rsp_card_addr;
  logic [1:0]  rsp_space;
  logic [3:0]  rsp_hold, rsp_setup;
  logic [4:0]  rsp_strobe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  card_window_decoder uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_go(rsp_go), .rsp_wp_err(rsp_wp_err),
    .rsp_win(rsp_win), .rsp_card_addr(rsp_card_addr), .rsp_slot(rsp_slot),
    .rsp_space(rsp_space), .rsp_wide(rsp_wide), .rsp_hold(rsp_hold),
    .rsp_setup(rsp_setup), .rsp_strobe(rsp_strobe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_opt(input int code, input int hold, input int setup,
                                         input int strobe, input bit wide, input int space,
                                         input bit slot, input bit wp, input bit valid);
    return (32'(code) << 27) | (32'(hold) << 16) | (32'(setup) << 12) | (32'(strobe) << 7) |
           (32'(wide) << 6) | (32'(space) << 3) | (32'(slot) << 2) | (32'(wp) << 1) | 32'(valid);
  endfunction

  // Size rule from R3/R4, computed from the code's bit pattern.
  function automatic int exp_log2(input int code);
    int gd;
    gd = ((code >> 1) & 1) * 2 + (((code >> 1) ^ code) & 1);
    if (code < 4)  return gd;
    if (code < 8)  return 7 - gd;
    if (code < 12) return 15 - gd;
    if (code < 16) return 8 + gd;
    if (code == 16) return 28;
    if (code == 20) return 24;
    if (code == 21) return 25;
    if (code == 23) return 26;
    if (code >= 24 && code < 28) return 16 + gd;
    if (code >= 28) return 23 - gd;
    return -1;
  endfunction

  task automatic cfg_write(input int win, input bit is_opt, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {3'(win), is_opt}; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] addr, input bit wr);
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 valid after reset", 32'(rsp_valid), 0);
    chk("R1 hit after reset", 32'(rsp_hit), 0);
    rst = 1'b0;
    lookup(32'h0000_0000, 0);
    chk("R1 zero address misses", 32'(rsp_hit), 0);
    chk("R11 rsp_valid follows", 32'(rsp_valid), 1);
    lookup(32'h4000_0000, 0);
    chk("R1 any address misses", 32'(rsp_hit), 0);

    // R3/R4/R5/R7: sweep every size code on window 0
    for (int c = 0; c < 32; c++) begin
      int l;
      logic [31:0] sz;
      l = exp_log2(c);
      cfg_write(0, 0, 32'h4000_0000);
      cfg_write(0, 1, mk_opt(c, 0, 0, 0, 0, 0, 0, 0, 1));
      lookup(32'h4000_0000, 0);
      if (l < 0) begin
        chk($sformatf("R4 reserved code %0d misses", c), 32'(rsp_hit), 0);
        chk("R11 miss no go", 32'(rsp_go), 0);
      end else begin
        sz = 32'd1 << l;
        chk($sformatf("R3 code %0d hits at base", c), 32'(rsp_hit), 1);
        chk("R7 offset at base", rsp_card_addr, 0);
        lookup(32'h4000_0000 + sz - 1, 0);
        chk($sformatf("R3 code %0d hits at top", c), 32'(rsp_hit), 1);
        chk($sformatf("R7 offset at top code %0d", c), rsp_card_addr, sz - 1);
        lookup(32'h4000_0000 + sz, 0);
        chk($sformatf("R3 code %0d misses past end", c), 32'(rsp_hit), 0);
        chk("R11 miss zero offset", rsp_card_addr, 0);
        lookup(32'h3FFF_FFFF, 0);
        chk($sformatf("R5 code %0d misses below", c), 32'(rsp_hit), 0);
      end
    end

    // R5: misaligned base never hits (4 KiB window, code 10)
    cfg_write(0, 0, 32'h4000_0010);
    cfg_write(0, 1, mk_opt(10, 0, 0, 0, 0, 0, 0, 0, 1));
    lookup(32'h4000_0010, 0);
    chk("R5 misaligned base misses", 32'(rsp_hit), 0);
    // R5: valid bit clear
    cfg_write(0, 0, 32'h4000_0000);
    cfg_write(0, 1, mk_opt(10, 0, 0, 0, 0, 0, 0, 0, 0));
    lookup(32'h4000_0004, 0);
    chk("R5 invalid window misses", 32'(rsp_hit), 0);

    // R8/R9/R7: every window with its own attributes, 16 MiB each (code 20)
    for (int w = 0; w < 8; w++) begin
      cfg_write(w, 0, 32'(w + 1) << 24);
      cfg_write(w, 1, mk_opt(20, w + 1, 7 - w, w * 3 + 1, w[1], w[2:1], w[0], 0, 1));
    end
    for (int w = 0; w < 8; w++) begin
      lookup((32'(w + 1) << 24) + 32'h0012_3456, 0);
      chk($sformatf("R7 win index w%0d", w), 32'(rsp_win), 32'(w));
      chk($sformatf("R7 offset w%0d", w), rsp_card_addr, 32'h0012_3456);
      chk($sformatf("R8 slot w%0d", w), 32'(rsp_slot), 32'(w & 1));
      chk($sformatf("R8 space w%0d", w), 32'(rsp_space), 32'((w >> 1) & 3));
      chk($sformatf("R8 wide w%0d", w), 32'(rsp_wide), 32'((w >> 1) & 1));
      chk($sformatf("R9 hold w%0d", w), 32'(rsp_hold), 32'(w + 1));
      chk($sformatf("R9 setup w%0d", w), 32'(rsp_setup), 32'(7 - w));
      chk($sformatf("R9 strobe w%0d", w), 32'(rsp_strobe), 32'(w * 3 + 1));
      chk($sformatf("R10 read goes w%0d", w), 32'(rsp_go), 1);
    end

    // R6: overlapping windows 2 (64 MiB) and 5 (256 MiB) at the same base
    cfg_write(2, 0, 32'h1000_0000);
    cfg_write(2, 1, mk_opt(23, 1, 1, 1, 0, 0, 0, 0, 1));
    cfg_write(5, 0, 32'h1000_0000);
    cfg_write(5, 1, mk_opt(16, 2, 2, 2, 1, 3, 1, 0, 1));
    lookup(32'h1000_0040, 0);
    chk("R6 lower index wins", 32'(rsp_win), 2);
    chk("R6 winner timing", 32'(rsp_hold), 1);
    lookup(32'h1400_0000, 0);
    chk("R6 only upper window", 32'(rsp_win), 5);
    chk("R6 upper offset", rsp_card_addr, 32'h0400_0000);
    cfg_write(2, 1, 32'h0);
    lookup(32'h1000_0040, 0);
    chk("R6 after disable upper wins", 32'(rsp_win), 5);
    chk("R6 upper space", 32'(rsp_space), 3);

    // R10: write protection on window 3
    cfg_write(3, 1, mk_opt(20, 4, 4, 4, 0, 2, 1, 1, 1));
    lookup(32'h0400_0100, 1);
    chk("R10 protected write flags", 32'(rsp_wp_err), 1);
    chk("R10 protected write no go", 32'(rsp_go), 0);
    chk("R10 protected write still hits", 32'(rsp_hit), 1);
    lookup(32'h0400_0100, 0);
    chk("R10 protected read no flag", 32'(rsp_wp_err), 0);
    chk("R10 protected read goes", 32'(rsp_go), 1);
    lookup(32'h0500_0100, 1);
    chk("R10 unprotected write goes", 32'(rsp_go), 1);
    lookup(32'h3000_0000, 1);
    chk("R10 write miss no flag", 32'(rsp_wp_err), 0);

    // R2: write and lookup in the same cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {3'd6, 1'b1}; cfg_wdata = 32'h0;
    req_valid = 1'b1; req_addr = 32'h0700_0010; req_write = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    chk("R2 same-cycle sees old option", 32'(rsp_hit), 1);
    chk("R2 same-cycle old window", 32'(rsp_win), 6);
    lookup(32'h0700_0010, 0);
    chk("R2 next cycle sees cleared option", 32'(rsp_hit), 0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {3'd7, 1'b0}; cfg_wdata = 32'h3000_0000;
    req_valid = 1'b1; req_addr = 32'h3000_0020; req_write = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    chk("R2 same-cycle sees old base", 32'(rsp_hit), 0);
    lookup(32'h3000_0020, 0);
    chk("R2 next cycle sees new base", 32'(rsp_hit), 1);
    chk("R2 new base window", 32'(rsp_win), 7);
    chk("R2 new base offset", rsp_card_addr, 32'h20);

    @(negedge clk);
    chk("R11 idle drops valid", 32'(rsp_valid), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule